// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Clear-Only Status Flags

This block receives character-framed asynchronous serial data for a microcontroller-style serial port. A hidden shift stage follows the receive line at sixteen samples per bit. The samples are paced by a tick from an external baud generator. The shift stage checks the start bit, assembles the data bits, the optional parity bit and the stop bits, and then hands the character to a data register that software can read. Because the shift stage and the data register are separate, the next character can arrive while software is still reading the last one.

The frame format is set by static controls: 7 or 8 data bits, parity off, even or odd, one or two stop bits, and bit order (MSB-first applies to 8-bit characters only). Four sticky flags report the receive state: data ready, overrun, framing error and parity error. Only hardware sets them. Software clears them through a small write port, where a 0 in a flag's position clears that flag. One enable gates both the receive interrupt request and the error interrupt request.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `data_o` is 0, all four flags are 0 and both interrupt requests are 0.
- R2: With `rx_en_i`=1, 8 data bits, no parity and LSB-first, a valid frame loads the character into `data_o` with the first data bit in bit 0, and sets `rdy_o` at the centre of the last stop bit.
- R3: With `chr7_i`=1, 7 data bits are taken LSB-first into `data_o[6:0]`, and `data_o[7]` reads 0. `msb_first_i` is ignored in this mode.
- R4: With `chr7_i`=0 and `msb_first_i`=1, the first data bit on the line lands in `data_o[7]`.
- R5: With `par_en_i`=1, one parity bit follows the data. With `par_odd_i`=0 the data bits plus the parity bit must hold an even number of ones; with `par_odd_i`=1 an odd number. On a mismatch `per_o` sets, and the character is still loaded with `rdy_o` set.
- R6: When the first stop bit samples 0, `fer_o` sets and the character is loaded into `data_o`, but `rdy_o` stays 0.
- R7: When a frame completes while `rdy_o`=1, `ovr_o` sets, `data_o` keeps its old value and the new character is dropped.
- R8: While `ovr_o` or `fer_o` is 1, completed frames are dropped: `data_o` and `rdy_o` do not change.
- R9: A cycle with `clr_we_i`=1 clears every flag whose bit in `clr_wdata_i` is 0 (bit 0 ready, bit 1 overrun, bit 2 framing, bit 3 parity). A 1 in a bit leaves that flag unchanged.
- R10: A start bit is accepted only if the line is still low 8 ticks after the falling edge. A shorter low pulse returns the receiver to idle with no effect on the flags.
- R11: While `rx_en_i`=0, the receiver stays idle and no frame changes `data_o` or any flag.
- R12: `rx_irq_o` equals `rdy_o` AND `irq_en_i`. `err_irq_o` equals (`ovr_o` OR `fer_o` OR `per_o`) AND `irq_en_i`.
- R13: With `stop2_i`=1, the character is delivered at the centre of the second stop bit, not the first. Only the first stop bit is checked for a framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| os_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_i | input | 1 | Serial receive line, idle high |
| rx_en_i | input | 1 | Receive enable |
| chr7_i | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| stop2_i | input | 1 | 1 = two stop bits |
| msb_first_i | input | 1 | MSB-first order for 8-bit characters |
| irq_en_i | input | 1 | Enable for both interrupt requests |
| clr_we_i | input | 1 | Flag clear write strobe |
| clr_wdata_i | input | 4 | Clear mask; a 0 clears the flag in that position |
| data_o | output | 8 | Received character register |
| rdy_o | output | 1 | Data-ready flag |
| ovr_o | output | 1 | Overrun flag |
| fer_o | output | 1 | Framing error flag |
| per_o | output | 1 | Parity error flag |
| rx_irq_o | output | 1 | Receive interrupt request |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
The main path is driven with characters of unbalanced bit patterns in four formats: 8-bit LSB-first, 8-bit MSB-first, 7-bit with the order control set, and with even and odd parity. Each format would show a different value if bits were reversed, shifted or the parity sense inverted. Error patterns are a low first stop bit, a second character arriving while the first is unread, and frames arriving while an error flag is pending. These tell apart the three outcomes at frame completion: load, drop with overrun, and silent drop. A short low glitch, a frame with reception disabled, and a two-stop-bit frame probed between its stop bits separate start validation, enable gating and the delivery point.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int FLAG_W  = 4;
  localparam int FLG_RDY = 0;
  localparam int FLG_OVR = 1;
  localparam int FLG_FER = 2;
  localparam int FLG_PER = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic chr7;
    logic par_en;
    logic par_odd;
    logic stop2;
    logic msb_first;
  } rx_fmt_t;
endpackage

// File: rtl/rxs_sync.sv
module rxs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rxs_framer.sv
module rxs_framer
  import rxs_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              en_i,
  input  rx_fmt_t           fmt_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              stop_bad_o,
  output logic              par_bad_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int MID   = OSR / 2;
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              par_q;
  logic              stop_bad_q;
  logic              prev_q;
  logic              done_q;

  logic [IDX_W-1:0]  last_idx;
  logic              msb_mode;
  logic              bit_end;

  assign last_idx = fmt_i.chr7 ? IDX_W'(DATA_W - 2) : IDX_W'(DATA_W - 1);
  assign msb_mode = fmt_i.msb_first && !fmt_i.chr7;
  assign bit_end  = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      shift_q    <= '0;
      par_q      <= 1'b0;
      stop_bad_q <= 1'b0;
      prev_q     <= 1'b1;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) prev_q <= rx_i;
      if (!en_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        case (state_q)
          ST_IDLE: begin
            cnt_q <= '0;
            if (prev_q && !rx_i) state_q <= ST_START;
          end
          ST_START: begin
            if (cnt_q == CNT_MID) begin
              cnt_q <= '0;
              if (rx_i) begin
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_DATA;
                idx_q   <= '0;
                par_q   <= 1'b0;
                shift_q <= '0;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (bit_end) begin
              cnt_q <= '0;
              par_q <= par_q ^ rx_i;
              if (msb_mode) shift_q <= {shift_q[DATA_W-2:0], rx_i};
              else          shift_q <= {rx_i, shift_q[DATA_W-1:1]};
              if (idx_q == last_idx) state_q <= fmt_i.par_en ? ST_PAR : ST_STOP1;
              else                   idx_q   <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (bit_end) begin
              cnt_q   <= '0;
              par_q   <= par_q ^ rx_i;
              state_q <= ST_STOP1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP1: begin
            if (bit_end) begin
              cnt_q      <= '0;
              stop_bad_q <= !rx_i;
              if (fmt_i.stop2) begin
                state_q <= ST_STOP2;
              end else begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP2: begin
            if (bit_end) begin
              cnt_q   <= '0;
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // 7-bit characters sit one place high after LSB-first shifting
  assign data_o     = fmt_i.chr7 ? {1'b0, shift_q[DATA_W-1:1]} : shift_q;
  assign stop_bad_o = stop_bad_q;
  assign par_bad_o  = fmt_i.par_en && (par_q != fmt_i.par_odd);
  assign done_o     = done_q;

  // R11
  dis_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == ST_IDLE);

  // R10
  start_rej_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick_i && cnt_q == CNT_MID && rx_i) |=> state_q == ST_IDLE);

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/rxs_flags.sv
module rxs_flags
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  logic              stop_bad_i,
  input  logic              par_bad_i,
  input  logic              clr_we_i,
  input  logic [FLAG_W-1:0] clr_wdata_i,
  output logic [DATA_W-1:0] data_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [DATA_W-1:0] data_q;
  logic rdy_q, ovr_q, fer_q, per_q;
  logic blocked;

  assign blocked = ovr_q || fer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      fer_q  <= 1'b0;
      per_q  <= 1'b0;
    end else begin
      if (clr_we_i) begin
        rdy_q <= rdy_q & clr_wdata_i[FLG_RDY];
        ovr_q <= ovr_q & clr_wdata_i[FLG_OVR];
        fer_q <= fer_q & clr_wdata_i[FLG_FER];
        per_q <= per_q & clr_wdata_i[FLG_PER];
      end
      // hardware set wins over a same-cycle clear
      if (done_i) begin
        if (rdy_q) begin
          ovr_q <= 1'b1;
        end else if (!blocked) begin
          data_q <= frame_data_i;
          if (stop_bad_i) fer_q <= 1'b1;
          else            rdy_q <= 1'b1;
          if (par_bad_i)  per_q <= 1'b1;
        end
      end
    end
  end

  assign data_o = data_q;
  always_comb begin
    flags_o          = '0;
    flags_o[FLG_RDY] = rdy_q;
    flags_o[FLG_OVR] = ovr_q;
    flags_o[FLG_FER] = fer_q;
    flags_o[FLG_PER] = per_q;
  end

  // R2
  rdy_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> !$rose(rdy_q));

  // R9
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> !($rose(ovr_q) || $rose(fer_q) || $rose(per_q)));

  // R7
  ovr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && rdy_q) |=> ovr_q && $stable(data_q));

  // R8
  blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !rdy_q && blocked) |=> $stable(data_q) && !$rose(rdy_q));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import rxs_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              os_tick_i,
  input  logic              rx_i,
  input  logic              rx_en_i,
  input  logic              chr7_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  input  logic              msb_first_i,
  input  logic              irq_en_i,
  input  logic              clr_we_i,
  input  logic [3:0]        clr_wdata_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o,
  output logic              ovr_o,
  output logic              fer_o,
  output logic              per_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);
  logic              rx_s;
  rx_fmt_t           fmt;
  logic              done;
  logic [DATA_W-1:0] frame_data;
  logic              stop_bad, par_bad;
  logic [FLAG_W-1:0] flags;

  assign fmt = '{chr7: chr7_i, par_en: par_en_i, par_odd: par_odd_i,
                 stop2: stop2_i, msb_first: msb_first_i};

  rxs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  rxs_framer #(.OSR(OSR), .DATA_W(DATA_W)) u_framer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (os_tick_i),
    .rx_i      (rx_s),
    .en_i      (rx_en_i),
    .fmt_i     (fmt),
    .done_o    (done),
    .data_o    (frame_data),
    .stop_bad_o(stop_bad),
    .par_bad_o (par_bad)
  );

  rxs_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done),
    .frame_data_i(frame_data),
    .stop_bad_i  (stop_bad),
    .par_bad_i   (par_bad),
    .clr_we_i    (clr_we_i),
    .clr_wdata_i (clr_wdata_i),
    .data_o      (data_o),
    .flags_o     (flags)
  );

  assign rdy_o     = flags[FLG_RDY];
  assign ovr_o     = flags[FLG_OVR];
  assign fer_o     = flags[FLG_FER];
  assign per_o     = flags[FLG_PER];
  assign rx_irq_o  = irq_en_i && flags[FLG_RDY];
  assign err_irq_o = irq_en_i && (flags[FLG_OVR] || flags[FLG_FER] || flags[FLG_PER]);
endmodule

// File: tb/uart_rx_status_bench.sv
`timescale 1ns/1ps
module uart_rx_status_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OSR        = 16;
  localparam int TD         = 4;
  localparam int BIT_CLKS   = OSR * TD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rx = 1'b1;
  logic rx_en = 1'b0, chr7 = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic stop2 = 1'b0, msb = 1'b0, irq_en = 1'b0, clr_we = 1'b0;
  logic [3:0] clr_wd = 4'hf;
  logic [7:0] data;
  logic rdy, ovr, fer, per, rx_irq, err_irq;

  int total = 0;
  int bad = 0;
  bit in_frame = 1'b0;
  bit finished = 1'b0;

  logic [7:0] m_data = 8'h00;
  bit m_rdy = 0, m_ovr = 0, m_fer = 0, m_per = 0;

  uart_rx_status u_uart_rx_status (
    .clk_i(clk), .rst_ni(rst_n), .os_tick_i(tick), .rx_i(rx),
    .rx_en_i(rx_en), .chr7_i(chr7), .par_en_i(par_en), .par_odd_i(par_odd),
    .stop2_i(stop2), .msb_first_i(msb), .irq_en_i(irq_en),
    .clr_we_i(clr_we), .clr_wdata_i(clr_wd),
    .data_o(data), .rdy_o(rdy), .ovr_o(ovr), .fer_o(fer), .per_o(per),
    .rx_irq_o(rx_irq), .err_irq_o(err_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == 0);
      c = (c + 1) % TD;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the behavioural model
  always @(posedge clk) begin
    #2;
    if (!in_frame && !finished) begin
      chk("R2 data", data, m_data);
      chk("R2 rdy", {7'd0, rdy}, {7'd0, m_rdy});
      chk("R7 ovr", {7'd0, ovr}, {7'd0, m_ovr});
      chk("R6 fer", {7'd0, fer}, {7'd0, m_fer});
      chk("R5 per", {7'd0, per}, {7'd0, m_per});
      chk("R12 rx_irq", {7'd0, rx_irq}, {7'd0, bit'(m_rdy && irq_en)});
      chk("R12 err_irq", {7'd0, err_irq},
          {7'd0, bit'((m_ovr || m_fer || m_per) && irq_en)});
    end
  end

  task automatic wait_bits(input int n);
    repeat (n * BIT_CLKS) @(negedge clk);
  endtask

  task automatic clr(input logic [3:0] w);
    @(negedge clk);
    clr_we = 1'b1;
    clr_wd = w;
    @(posedge clk);
    #1;
    m_rdy = m_rdy & w[0];
    m_ovr = m_ovr & w[1];
    m_fer = m_fer & w[2];
    m_per = m_per & w[3];
    @(negedge clk);
    clr_we = 1'b0;
    clr_wd = 4'hf;
  endtask

  task automatic send(input logic [7:0] val, input bit par_bad, input bit stop_ok);
    int nb;
    logic [7:0] bits;
    logic p;
    logic [7:0] exp_byte;
    bit pre_rdy;
    nb = chr7 ? 7 : 8;
    bits = 8'h00;
    for (int i = 0; i < nb; i++) bits[i] = (msb && !chr7) ? val[7-i] : val[i];
    p = 1'b0;
    for (int i = 0; i < nb; i++) p = p ^ bits[i];
    if (par_odd) p = ~p;
    p = p ^ par_bad;
    exp_byte = chr7 ? {1'b0, val[6:0]} : val;
    pre_rdy = m_rdy;
    @(negedge clk);
    in_frame = 1'b1;
    rx = 1'b0;
    wait_bits(1);
    for (int i = 0; i < nb; i++) begin
      rx = bits[i];
      wait_bits(1);
    end
    if (par_en) begin
      rx = p;
      wait_bits(1);
    end
    rx = stop_ok;
    wait_bits(1);
    if (stop2) begin
      if (rx_en && !pre_rdy && !m_ovr && !m_fer)
        chk("R13 not ready after first stop", {7'd0, rdy}, 8'd0);
      rx = 1'b1;
      wait_bits(1);
    end
    rx = 1'b1;
    if (rx_en) begin
      if (m_rdy) m_ovr = 1;
      else if (!(m_ovr || m_fer)) begin
        m_data = exp_byte;
        if (!stop_ok) m_fer = 1; else m_rdy = 1;
        if (par_en && par_bad) m_per = 1;
      end
    end
    repeat (4 * TD) @(negedge clk);
    in_frame = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 data", data, 8'h00);
    chk("R1 flags", {4'd0, per, fer, ovr, rdy}, 8'h00);
    chk("R1 irq", {6'd0, err_irq, rx_irq}, 8'h00);
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (8) @(negedge clk);

    // R2 basic 8N1 LSB-first
    send(8'hA5, 0, 1);
    chk("R2 data A5", data, 8'hA5);
    chk("R12 rx_irq off", {7'd0, rx_irq}, 8'd0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R12 rx_irq on", {7'd0, rx_irq}, 8'd1);
    clr(4'b1110);
    chk("R9 rdy cleared", {7'd0, rdy}, 8'd0);

    send(8'h3C, 0, 1);
    clr(4'b1111);
    chk("R9 write one keeps rdy", {7'd0, rdy}, 8'd1);

    // R7 overrun
    send(8'h81, 0, 1);
    chk("R7 ovr set", {7'd0, ovr}, 8'd1);
    chk("R7 data kept", data, 8'h3C);
    chk("R12 err_irq", {7'd0, err_irq}, 8'd1);
    clr(4'b1110);
    chk("R9 ovr kept", {7'd0, ovr}, 8'd1);
    // R8 drop while overrun pending
    send(8'h55, 0, 1);
    chk("R8 data kept", data, 8'h3C);
    chk("R8 rdy stays", {7'd0, rdy}, 8'd0);
    clr(4'b1101);
    send(8'h55, 0, 1);
    chk("R2 data 55", data, 8'h55);
    clr(4'b0000);

    // R6 framing error
    send(8'h0F, 0, 0);
    chk("R6 fer", {7'd0, fer}, 8'd1);
    chk("R6 data", data, 8'h0F);
    chk("R6 no rdy", {7'd0, rdy}, 8'd0);
    send(8'h11, 0, 1);
    chk("R8 dropped under fer", data, 8'h0F);
    clr(4'b1011);
    chk("R9 fer cleared", {7'd0, fer}, 8'd0);

    // R3 seven bits, order control ignored
    chr7 = 1'b1; msb = 1'b1;
    send(8'hC3, 0, 1);
    chk("R3 data", data, 8'h43);
    clr(4'b0000);

    // R4 MSB-first
    chr7 = 1'b0;
    send(8'h96, 0, 1);
    chk("R4 data", data, 8'h96);
    clr(4'b0000);
    msb = 1'b0;

    // R5 parity
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h07, 0, 1);
    chk("R5 even ok", {7'd0, per}, 8'd0);
    clr(4'b0000);
    send(8'h07, 1, 1);
    chk("R5 even bad", {7'd0, per}, 8'd1);
    chk("R5 still ready", {7'd0, rdy}, 8'd1);
    clr(4'b0110);
    chk("R9 per rdy cleared", {4'd0, per, fer, ovr, rdy}, 8'd0);
    par_odd = 1'b1;
    send(8'h07, 0, 1);
    chk("R5 odd ok", {7'd0, per}, 8'd0);
    send(8'h00, 0, 1);
    clr(4'b0000);
    chr7 = 1'b1;
    send(8'h2B, 1, 1);
    chk("R5 odd bad 7-bit", {7'd0, per}, 8'd1);
    clr(4'b0000);
    chr7 = 1'b0; par_en = 1'b0; par_odd = 1'b0;

    // R13 two stop bits
    stop2 = 1'b1;
    send(8'h5A, 0, 1);
    chk("R13 data", data, 8'h5A);
    clr(4'b0000);
    stop2 = 1'b0;

    // R10 glitch rejection
    @(negedge clk);
    in_frame = 1'b1;
    rx = 1'b0;
    repeat (4 * TD) @(negedge clk);
    rx = 1'b1;
    wait_bits(2);
    in_frame = 1'b0;
    @(negedge clk);
    chk("R10 no rdy", {7'd0, rdy}, 8'd0);
    send(8'h24, 0, 1);
    chk("R10 next frame", data, 8'h24);
    clr(4'b0000);

    // R11 receiver disabled
    rx_en = 1'b0;
    send(8'hFF, 0, 1);
    chk("R11 data", data, 8'h24);
    chk("R11 flags", {4'd0, per, fer, ovr, rdy}, 8'd0);

    repeat (10) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule